// File: doc/BRIEF.md
# Free-Running Timer Counter with Prescaler

This block is the counting core of a small programmable timer. A 16-bit up-counter runs without stopping and is read over an 8-bit register bus. Software sees the count through two views that always return the same value. Each view is split into a high byte and a low byte. The two views differ only in how they treat the overflow flag. The main view takes part in the flag's clear sequence. The alternate view lets software sample the count without disturbing that flag.

The counter has no zero reload. It starts at FFFCh on reset, and a write to either low byte returns it to FFFCh. A two-bit clock-select input chooses the tick source: the CPU clock divided by 2, 4 or 8, or a slow external clock that is synchronized and counted on its rising edge. When the count wraps from FFFFh to 0000h, the overflow flag is set. An interrupt request is raised while the flag is set and the interrupt enable input is high.

Reading a high byte captures the low byte of the same view. The next low-byte read of that view then forms a coherent 16-bit value with the high byte, even if the counter ticked in between.

Top module: `tmr_freerun`

## Requirements
- R1: While reset is high and after its release, the count is FFFCh, the overflow flag is 0 and `ovf_irq` is 0.
- R2: Each tick adds one to the count, and the count wraps from FFFFh to 0000h. Without a tick or a reload, the count holds.
- R3: `clk_sel` 00 ticks once every 4 clock cycles, 01 once every 2, and 10 once every 8. With 01 the wrap repeats every 131072 cycles. Code 11 ticks once for each rising edge of `ext_clk`. That edge passes through a two-stage synchronizer, so the count changes on the third clock edge after `ext_clk` is seen high.
- R4: A write (`bus_wr`=1) to address 2 or address 4 sets the count to FFFCh and clears the prescaler, whatever the value of `bus_wdata`. The first tick then comes a full divide period later. Writes to addresses 0, 1 and 3 change nothing.
- R5: Address map for `bus_rdata`: 0 is status, 1 is the main high byte, 2 the main low byte, 3 the alternate high byte and 4 the alternate low byte. Both views return the same count. Addresses 5 to 7 read 00h.
- R6: A wrap sets the overflow flag, which reads as bit 7 of status; status bits 6:0 read 0. `ovf_irq` is high exactly while the flag is 1 and `ovf_ie` is 1.
- R7: The flag clears only when a status read (`bus_rd`=1, address 0) sees it set and a later read or write of address 2 follows. An access to address 2 with no such status read leaves the flag set. A wrap in the same cycle as the clear leaves the flag set.
- R8: Reading address 4 never clears the overflow flag.
- R9: Reading address 1 or 3 captures the low byte of the count at that moment. Until that view's low byte is read, or either low byte is written, its low address returns the captured byte. Otherwise the low address returns the live low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data (ignored by every register) |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| clk_sel | input | 2 | Tick source: 00 /4, 01 /2, 10 /8, 11 external |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ext_clk | input | 1 | External tick clock, slower than half of `clk` |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench targets several corner cases:
- The wrap out of FFFCh four ticks after reset. A design that reloads to zero or counts from the wrong start sets the flag at the wrong cycle.
- The two-step flag clear: an access to the main low byte with no status read first, a status read followed by a main low access, and alternate low reads while the flag is set. A design that clears the flag on the wrong access drops `ovf_irq` early.
- Captured low bytes held across several ticks. A design that reads the live byte returns a torn value.
- Reload writes with non-zero data. A design that loads the written data breaks the count sequence.
- The /2 wrap period and the three-edge external latency, measured cycle by cycle. A design with an off-by-one divider or a short synchronizer drifts from the model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PRE_W = 3;

    typedef enum logic [1:0] {
        CS_DIV4 = 2'b00,
        CS_DIV2 = 2'b01,
        CS_DIV8 = 2'b10,
        CS_EXT  = 2'b11
    } clk_sel_e;

    typedef enum logic [2:0] {
        RA_STAT = 3'd0,
        RA_MHI  = 3'd1,
        RA_MLO  = 3'd2,
        RA_AHI  = 3'd3,
        RA_ALO  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [2:0] addr;
    } bus_req_t;

    // Division ratio for the internal tick sources; external returns 0.
    function automatic logic [PRE_W:0] div_of(input clk_sel_e sel);
        case (sel)
            CS_DIV2: div_of = 4'd2;
            CS_DIV4: div_of = 4'd4;
            CS_DIV8: div_of = 4'd8;
            default: div_of = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    input  logic     ext_clk,
    input  logic     clr,
    output logic     tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   last;
    logic             sync1_q, sync2_q, sync3_q;
    logic             int_tick;

    assign last     = div_of(sel) - 1'b1;
    assign int_tick = ({1'b0, pre_q} >= last);
    assign tick     = (sel == CS_EXT) ? (sync2_q & ~sync3_q) : int_tick;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (sel == CS_EXT || int_tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            sync3_q <= 1'b0;
        end else begin
            sync1_q <= ext_clk;
            sync2_q <= sync1_q;
            sync3_q <= sync2_q;
        end
    end

    // R3: an internal divider never ticks on two cycles in a row
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != CS_EXT && !clr) |=> (!tick || sel == CS_EXT));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] RELOAD_VAL = {CNT_W{1'b1}} - 3;
    localparam logic [CNT_W-1:0] ONE        = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    assign cnt  = cnt_q;
    assign wrap = tick & ~reload & (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            cnt_q <= RELOAD_VAL;
        end else if (tick) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cnt_q == RELOAD_VAL));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !reload) |=> (cnt_q == $past(cnt_q) + ONE));

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !reload) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
    import tmr_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [2*BUS_W-1:0] cnt,
    input  logic               wrap,
    input  logic               ovf_ie,
    output logic [BUS_W-1:0]   rdata,
    output logic               reload,
    output logic               irq
);
    localparam int CNT_W = 2 * BUS_W;

    logic [BUS_W-1:0] cnt_lo, cnt_hi;
    logic [BUS_W-1:0] view_lo [2];
    logic             ovf_q, armed_q;
    logic             mlo_acc, stat_rd;

    assign cnt_lo  = cnt[BUS_W-1:0];
    assign cnt_hi  = cnt[CNT_W-1 -: BUS_W];
    assign reload  = req.wr && (req.addr == RA_MLO || req.addr == RA_ALO);
    assign mlo_acc = (req.rd || req.wr) && req.addr == RA_MLO;
    assign stat_rd = req.rd && req.addr == RA_STAT;
    assign irq     = ovf_q & ovf_ie;

    // One capture register per view: a high read latches the low byte.
    for (genvar v = 0; v < 2; v++) begin : g_view
        localparam reg_addr_e HI = (v == 0) ? RA_MHI : RA_AHI;
        localparam reg_addr_e LO = (v == 0) ? RA_MLO : RA_ALO;
        logic [BUS_W-1:0] hold_q;
        logic             held_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q <= '0;
                held_q <= 1'b0;
            end else if (req.rd && req.addr == HI) begin
                hold_q <= cnt_lo;
                held_q <= 1'b1;
            end else if (reload || (req.rd && req.addr == LO)) begin
                held_q <= 1'b0;
            end
        end

        assign view_lo[v] = held_q ? hold_q : cnt_lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (wrap) begin
                ovf_q <= 1'b1;
            end else if (armed_q && mlo_acc) begin
                ovf_q <= 1'b0;
            end
            if (mlo_acc) begin
                armed_q <= 1'b0;
            end else if (stat_rd && ovf_q) begin
                armed_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (req.addr)
            RA_STAT: rdata = {ovf_q, {(BUS_W-1){1'b0}}};
            RA_MHI:  rdata = cnt_hi;
            RA_MLO:  rdata = view_lo[0];
            RA_AHI:  rdata = cnt_hi;
            RA_ALO:  rdata = view_lo[1];
            default: rdata = '0;
        endcase
    end

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_q);

    p_alt_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && req.rd && req.addr == RA_ALO) |=> ovf_q);

    p_clear_seq_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_q) |-> $past(armed_q && mlo_acc));

endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun
    import tmr_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [1:0]       clk_sel,
    input  logic             ovf_ie,
    input  logic             ext_clk,
    output logic             ovf_irq
);
    localparam int CNT_W = 2 * BUS_W;

    bus_req_t         req;
    logic [CNT_W-1:0] cnt;
    logic             tick, wrap, reload;
    logic             unused_wdata;

    assign req          = '{rd: bus_rd, wr: bus_wr, addr: bus_addr};
    assign unused_wdata = ^bus_wdata;

    tmr_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .sel     (clk_sel_e'(clk_sel)),
        .ext_clk (ext_clk),
        .clr     (reload),
        .tick    (tick)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .reload (reload),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    tmr_regbank #(.BUS_W(BUS_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .cnt    (cnt),
        .wrap   (wrap),
        .ovf_ie (ovf_ie),
        .rdata  (bus_rdata),
        .reload (reload),
        .irq    (ovf_irq)
    );

endmodule

// File: tb/tmr_freerun_tb.sv
`timescale 1ns/1ps
module tmr_freerun_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd = 1'b0, wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] sel = 2'b00;
    logic       ie = 1'b0;
    logic       ext = 1'b0;
    logic       irq;

    always #2.5 clk = ~clk;

    tmr_freerun u_dut (
        .clk(clk), .rst(rst), .bus_rd(rd), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .clk_sel(sel), .ovf_ie(ie),
        .ext_clk(ext), .ovf_irq(irq)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    finished = 0;

    // Behavioural reference state
    int   m_cnt, m_pre, m_div;
    bit   m_flag, m_arm, m_tick, m_rl, m_mlo, m_wrap;
    bit   m_held [2];
    int   m_hold [2];
    bit   e1, e2, e3;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 16'hFFFC; m_pre = 0; m_flag = 0; m_arm = 0;
            m_held[0] = 0; m_held[1] = 0; m_hold[0] = 0; m_hold[1] = 0;
            e1 = 0; e2 = 0; e3 = 0;
        end else begin
            m_div = (sel == 2'b00) ? 4 : (sel == 2'b01) ? 2 : (sel == 2'b10) ? 8 : 0;
            m_tick = (sel == 2'b11) ? (e2 && !e3) : (m_pre >= m_div - 1);
            m_rl   = wr && (addr == 3'd2 || addr == 3'd4);
            m_mlo  = (rd || wr) && addr == 3'd2;
            m_wrap = 0;
            if (rd && addr == 3'd1) begin m_hold[0] = m_cnt % 256; m_held[0] = 1; end
            else if (m_rl || (rd && addr == 3'd2)) m_held[0] = 0;
            if (rd && addr == 3'd3) begin m_hold[1] = m_cnt % 256; m_held[1] = 1; end
            else if (m_rl || (rd && addr == 3'd4)) m_held[1] = 0;
            if (m_rl) begin
                m_cnt = 16'hFFFC; m_pre = 0;
            end else begin
                if (m_tick) begin
                    if (m_cnt == 65535) m_wrap = 1;
                    m_cnt = (m_cnt + 1) % 65536;
                end
                m_pre = (sel == 2'b11 || m_pre >= m_div - 1) ? 0 : m_pre + 1;
            end
            if (m_wrap) m_flag = 1;
            else if (m_arm && m_mlo) m_flag = 0;
            if (m_mlo) m_arm = 0;
            else if (rd && addr == 3'd0 && m_flag) m_arm = 1;
            e3 = e2; e2 = e1; e1 = ext;
        end
    end

    function automatic int exp_rdata();
        case (addr)
            3'd0: return m_flag ? 8'h80 : 8'h00;
            3'd1, 3'd3: return m_cnt / 256;
            3'd2: return m_held[0] ? m_hold[0] : m_cnt % 256;
            3'd4: return m_held[1] ? m_hold[1] : m_cnt % 256;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        chk(cur_req, "bus_rdata", int'(rdata), exp_rdata());
        chk(cur_req, "ovf_irq", int'(irq), int'(m_flag && ie));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic rd_reg(input int a);
        addr = 3'(a); rd = 1'b1;
        step();
        rd = 1'b0;
    endtask

    task automatic wr_reg(input int a, input int d);
        addr = 3'(a); wdata = 8'(d); wr = 1'b1;
        step();
        wr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
            summary();
            $finish;
        end
    end

    int t_now, t_first, t_second;
    bit irq_prev;

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        rst = 1'b0;
        chk("R1", "status after reset", int'(rdata), 0);
        addr = 3'd1; #0.1;
        chk("R1", "high byte after reset", int'(rdata), 8'hFF);
        addr = 3'd2; #0.1;
        chk("R1", "low byte after reset", int'(rdata), 8'hFC);
        idle(2);

        // R5: whole address map
        cur_req = "R5";
        for (int a = 0; a < 8; a++) begin addr = 3'(a); step(); end

        // R2 and R6: run through the first wrap at /4, enable irq later
        cur_req = "R2";
        addr = 3'd2; idle(20);
        cur_req = "R6";
        addr = 3'd0; idle(2);
        ie = 1'b1; idle(2);

        // R8: alternate low reads leave the flag alone
        cur_req = "R8";
        rd_reg(0); rd_reg(4); rd_reg(4); addr = 3'd0; idle(2);

        // R7: the clear sequence
        cur_req = "R7";
        wr_reg(0, 0); rd_reg(1);
        rd_reg(2);              // armed by the earlier status read: clears
        addr = 3'd0; idle(2);
        wr_reg(2, 8'h00);       // reload, then let it wrap again
        addr = 3'd0; idle(18);
        rd_reg(2);              // no status read first: flag must stay
        addr = 3'd0; idle(2);
        rd_reg(0); idle(3); wr_reg(2, 8'h33);  // write access also clears
        addr = 3'd0; idle(2);

        // R9: coherent capture in both views
        cur_req = "R9";
        rd_reg(1); addr = 3'd2; idle(9); rd_reg(2); idle(2);
        rd_reg(3); addr = 3'd4; idle(7); rd_reg(4); idle(2);
        rd_reg(3); wr_reg(2, 0); addr = 3'd4; idle(3);

        // R4: reload ignores data; other writes do nothing
        cur_req = "R4";
        addr = 3'd2; idle(5);
        wr_reg(4, 8'hA5); addr = 3'd2; idle(3);
        wr_reg(1, 8'h12); wr_reg(3, 8'h34); wr_reg(0, 8'hFF);
        addr = 3'd1; idle(3); addr = 3'd2; idle(3);

        // R3: each internal divider and the external source
        cur_req = "R3";
        sel = 2'b10; wr_reg(2, 0); addr = 3'd2; idle(40);
        sel = 2'b01; wr_reg(2, 0); addr = 3'd2; idle(20);
        sel = 2'b11; wr_reg(2, 0); addr = 3'd2;
        for (int p = 0; p < 6; p++) begin
            ext = 1'b1; idle(3);
            ext = 1'b0; idle(4);
        end
        sel = 2'b00; wr_reg(2, 0); addr = 3'd2; idle(12);

        // R3: full /2 period measured between two irq rises
        sel = 2'b01; ie = 1'b1;
        rd_reg(0); wr_reg(2, 0);  // clears the flag and reloads
        t_now = 0; t_first = -1; t_second = -1; irq_prev = irq;
        addr = 3'd0;
        while (t_second < 0 && t_now < 140000) begin
            step();
            t_now++;
            if (irq && !irq_prev) begin
                if (t_first < 0) begin
                    t_first = t_now;
                    rd = 1'b1; step(); rd = 1'b0; t_now++;
                    addr = 3'd2; rd = 1'b1; step(); rd = 1'b0; t_now++;
                    addr = 3'd0;
                end else begin
                    t_second = t_now;
                end
            end
            irq_prev = irq;
        end
        chk("R3", "first wrap cycle after reload", t_first, 8);
        chk("R3", "wrap period at /2", t_second - t_first, 131072);

        finished = 1;
        summary();
        $finish;
    end

endmodule